// File: doc/BRIEF.md
# Taint propagation response cache

This block remembers the answers that a software taint-propagation handler has already given. Each retiring instruction is described by a lookup key made of its opcode, the taint states of its two source registers and the taint state of its memory operand. When a key has been seen before, the block returns the stored output taint state and exception flag, and the handler does not need to run. When the key is not present, the block reports a miss. The surrounding logic then runs the handler and writes its answer back through the fill port.

The cache is direct mapped. The full key is folded into a 7-bit index by XORing successive 7-bit slices of the key, which gives 128 entries. Every entry keeps the complete unfolded key as its tag, so two keys that land on the same index can never be mistaken for each other. A write to the handler-address register makes every stored answer stale, so the same strobe wipes the whole cache in one cycle. The width of a taint state is a parameter that may be set from 1 to 16 bits per word.

Top module: `tpc_cache`

## Requirements
- R1: A lookup presented with `lk_valid` high in one cycle produces `rsp_valid` high in the following cycle, with `rsp_hit`, `rsp_state` and `rsp_exc` valid in that same cycle.
- R2: The key is the concatenation {opcode, src1 state, src2 state, memory state}, with the opcode in the most significant bits and the memory state in the least significant bits. The index is the XOR of its 7-bit slices taken from bit 0 upward, with the top slice zero-padded.
- R3: A lookup hits only when the entry at its index is valid and its stored tag equals the full key. A different key that folds to the same index misses.
- R4: On a hit, `rsp_state` and `rsp_exc` equal the output state and exception bit of the most recent accepted fill for that key.
- R5: On a miss, `rsp_hit`, `rsp_state` and `rsp_exc` are all 0.
- R6: An accepted fill writes the entry at its key's index and replaces whatever key was stored there before.
- R7: A cycle with `handler_addr_wr` high invalidates every entry. Lookups in later cycles miss until the entry is filled again.
- R8: When `handler_addr_wr` and `fill_valid` are high in the same cycle, the fill is dropped and the flush takes effect.
- R9: A lookup in the same cycle as a fill or a flush sees the cache contents as they were before that cycle's update.
- R10: While `rst_n` is low, all entries become invalid and `rsp_valid` and `rsp_hit` are 0 in the cycle after.
- R11: In a cycle that follows a cycle without a lookup, `rsp_valid` and `rsp_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| handler_addr_wr | input | 1 | Strobe marking a write to the handler-address register; flushes the cache |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_opcode | input | OPC_W | Opcode of the lookup key |
| lk_src1 | input | STATE_W | Taint state of source register 1 |
| lk_src2 | input | STATE_W | Taint state of source register 2 |
| lk_mem | input | STATE_W | Taint state of the memory operand |
| fill_valid | input | 1 | Write a handler answer this cycle |
| fill_opcode | input | OPC_W | Opcode of the fill key |
| fill_src1 | input | STATE_W | Source register 1 state of the fill key |
| fill_src2 | input | STATE_W | Source register 2 state of the fill key |
| fill_mem | input | STATE_W | Memory state of the fill key |
| fill_state | input | STATE_W | Output taint state returned by the handler |
| fill_exc | input | 1 | Exception verdict returned by the handler |
| rsp_valid | output | 1 | Response to the previous cycle's lookup |
| rsp_hit | output | 1 | The previous lookup found its key |
| rsp_state | output | STATE_W | Cached output state, 0 on a miss |
| rsp_exc | output | 1 | Cached exception bit, 0 on a miss |

## Verification
Every part of the internal state shows at the ports one cycle after a lookup touches it. A valid bit that is set when it should be clear, for example after a flush, after a dropped fill or after reset, shows up as a hit where a miss is due. A tag or index that is wrong shows up either as a hit for a colliding key or as a miss on a key that was just filled. Data that is corrupted shows up as a wrong state or exception value on the next hit. The stimulus therefore makes sure that, for each kind of update, the affected entry is read again within a cycle or two. It also uses keys that collide on one index, so that an error in the fold or the tag compare cannot stay hidden.

// File: rtl/tpc_pkg.sv
// Package: shared constants and helpers for the taint propagation response cache.
// Assumes nothing beyond integer parameters being positive.
package tpc_pkg;

    // Index width fixed by the 128-entry organisation.
    localparam int TPC_IDX_W = 7;

    // Widest taint state the cache is built for.
    localparam int TPC_MAX_STATE_W = 16;

    // Integer ceiling division, used to count fold slices.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/tpc_fold.sv
// Module: tpc_fold
// Folds a key into an index by XORing successive IDX_W-bit slices, starting
// at bit 0; the top slice is zero-padded. Purely combinational.
// Assumes KEY_W >= 1 and IDX_W >= 1.
module tpc_fold
    import tpc_pkg::*;
#(
    parameter int KEY_W = 14,
    parameter int IDX_W = 7
) (
    input  logic [KEY_W-1:0] key,
    output logic [IDX_W-1:0] idx
);

    localparam int NSL   = ceil_div(KEY_W, IDX_W);
    localparam int PAD_W = NSL * IDX_W;

    logic [PAD_W-1:0] padded;

    // Zero-extend the key to a whole number of slices.
    assign padded = PAD_W'(key);

    // XOR all slices together into the index.
    always_comb begin
        idx = '0;
        for (int s = 0; s < NSL; s++) begin
            idx = idx ^ padded[s*IDX_W +: IDX_W];
        end
    end

endmodule

// File: rtl/tpc_store.sv
// Module: tpc_store
// Direct-mapped entry storage: one valid bit, one tag and one data word per
// index. Reads are combinational and return the contents before this cycle's
// write. A clear wipes every valid bit in one cycle and overrides a write;
// the caller is expected to gate wr_en with clr as well.
// Assumes synchronous active-low reset; tag and data arrays are not reset.
module tpc_store #(
    parameter int IDX_W = 7,
    parameter int TAG_W = 14,
    parameter int DAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [DAT_W-1:0] wr_dat,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag,
    output logic [DAT_W-1:0] rd_dat
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [DAT_W-1:0] dat_q [DEPTH];

    // Valid bits: reset and clear wipe all, otherwise a write sets one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and data arrays: written on an accepted write.
    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            tag_q[wr_idx] <= wr_tag;
            dat_q[wr_idx] <= wr_dat;
        end
    end

    // Read port: current contents at the lookup index.
    always_comb begin
        rd_vld = vld_q[rd_idx];
        rd_tag = tag_q[rd_idx];
        rd_dat = dat_q[rd_idx];
    end

endmodule

// File: rtl/tpc_resp.sv
// Module: tpc_resp
// Compares the stored tag with the lookup key and registers the response.
// A miss drives zero data. Assumes the read port data belongs to lk_key's index.
module tpc_resp #(
    parameter int KEY_W = 14,
    parameter int DAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [KEY_W-1:0] lk_key,
    input  logic             rd_vld,
    input  logic [KEY_W-1:0] rd_tag,
    input  logic [DAT_W-1:0] rd_dat,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [DAT_W-1:0] rsp_dat
);

    logic hit_c;

    // Hit only for a valid entry holding exactly this key.
    assign hit_c = lk_valid && rd_vld && (rd_tag == lk_key);

    // Response register: one cycle after the lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_dat   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= hit_c;
            rsp_dat   <= hit_c ? rd_dat : '0;
        end
    end

endmodule

// File: rtl/tpc_cache.sv
// Module: tpc_cache (top)
// Direct-mapped cache of software taint-handler verdicts. The key is
// {opcode, src1, src2, mem}; it is folded to IDX_W bits for the index and kept
// whole as the tag. Lookup result one cycle later. The handler-address write
// strobe flushes all entries and beats a simultaneous fill.
// Assumes 1 <= STATE_W <= 16 and synchronous active-low reset.
module tpc_cache
    import tpc_pkg::*;
#(
    parameter int OPC_W   = 8,
    parameter int STATE_W = 2,
    parameter int IDX_W   = TPC_IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               handler_addr_wr,
    input  logic               lk_valid,
    input  logic [OPC_W-1:0]   lk_opcode,
    input  logic [STATE_W-1:0] lk_src1,
    input  logic [STATE_W-1:0] lk_src2,
    input  logic [STATE_W-1:0] lk_mem,
    input  logic               fill_valid,
    input  logic [OPC_W-1:0]   fill_opcode,
    input  logic [STATE_W-1:0] fill_src1,
    input  logic [STATE_W-1:0] fill_src2,
    input  logic [STATE_W-1:0] fill_mem,
    input  logic [STATE_W-1:0] fill_state,
    input  logic               fill_exc,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [STATE_W-1:0] rsp_state,
    output logic               rsp_exc
);

    localparam int KEY_W = OPC_W + 3 * STATE_W;
    localparam int DAT_W = STATE_W + 1;

    logic [KEY_W-1:0] lk_key, fl_key, rd_tag;
    logic [IDX_W-1:0] lk_idx, fl_idx;
    logic [DAT_W-1:0] rd_dat, rsp_dat;
    logic             rd_vld, wr_en;

    // Assemble the lookup and fill keys in the same field order.
    assign lk_key = {lk_opcode, lk_src1, lk_src2, lk_mem};
    assign fl_key = {fill_opcode, fill_src1, fill_src2, fill_mem};

    // Flush has priority: a fill in a flush cycle is dropped.
    assign wr_en = fill_valid && !handler_addr_wr;

    tpc_fold #(.KEY_W(KEY_W), .IDX_W(IDX_W)) i_fold_lk (
        .key (lk_key),
        .idx (lk_idx)
    );

    tpc_fold #(.KEY_W(KEY_W), .IDX_W(IDX_W)) i_fold_fl (
        .key (fl_key),
        .idx (fl_idx)
    );

    tpc_store #(.IDX_W(IDX_W), .TAG_W(KEY_W), .DAT_W(DAT_W)) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (handler_addr_wr),
        .wr_en  (wr_en),
        .wr_idx (fl_idx),
        .wr_tag (fl_key),
        .wr_dat ({fill_state, fill_exc}),
        .rd_idx (lk_idx),
        .rd_vld (rd_vld),
        .rd_tag (rd_tag),
        .rd_dat (rd_dat)
    );

    tpc_resp #(.KEY_W(KEY_W), .DAT_W(DAT_W)) i_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_key    (lk_key),
        .rd_vld    (rd_vld),
        .rd_tag    (rd_tag),
        .rd_dat    (rd_dat),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_dat   (rsp_dat)
    );

    // Split the registered verdict into its two output fields.
    assign rsp_state = rsp_dat[DAT_W-1:1];
    assign rsp_exc   = rsp_dat[0];

endmodule

// File: rtl/tpc_cache_chk.sv
// Module: tpc_cache_chk
// Port-level properties of tpc_cache, attached to it with bind.
module tpc_cache_chk #(
    parameter int OPC_W   = 8,
    parameter int STATE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               handler_addr_wr,
    input logic               lk_valid,
    input logic [OPC_W-1:0]   lk_opcode,
    input logic [STATE_W-1:0] lk_src1,
    input logic [STATE_W-1:0] lk_src2,
    input logic [STATE_W-1:0] lk_mem,
    input logic               fill_valid,
    input logic [OPC_W-1:0]   fill_opcode,
    input logic [STATE_W-1:0] fill_src1,
    input logic [STATE_W-1:0] fill_src2,
    input logic [STATE_W-1:0] fill_mem,
    input logic [STATE_W-1:0] fill_state,
    input logic               fill_exc,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [STATE_W-1:0] rsp_state,
    input logic               rsp_exc
);

    localparam int KEY_W = OPC_W + 3 * STATE_W;

    logic [KEY_W-1:0] k_lk, k_fl;
    assign k_lk = {lk_opcode, lk_src1, lk_src2, lk_mem};
    assign k_fl = {fill_opcode, fill_src1, fill_src2, fill_mem};

    // R1: a lookup is answered in the next cycle.
    p_rsp_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R11: no lookup, no response.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit));

    // R5: a miss carries zero data.
    p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_state == '0 && !rsp_exc));

    // R7: a lookup right after a flush misses.
    p_flush_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_addr_wr ##1 lk_valid) |=> !rsp_hit);

    // R4: a fill followed at once by a lookup of the same key hits with its data.
    p_fill_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((fill_valid && !handler_addr_wr) ##1 (lk_valid && k_lk == $past(k_fl)))
        |=> (rsp_hit && rsp_state == $past(fill_state, 2) && rsp_exc == $past(fill_exc, 2)));

    // R10: reset clears the response.
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !rsp_hit));

endmodule

bind tpc_cache tpc_cache_chk #(.OPC_W(OPC_W), .STATE_W(STATE_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .handler_addr_wr (handler_addr_wr),
    .lk_valid        (lk_valid),
    .lk_opcode       (lk_opcode),
    .lk_src1         (lk_src1),
    .lk_src2         (lk_src2),
    .lk_mem          (lk_mem),
    .fill_valid      (fill_valid),
    .fill_opcode     (fill_opcode),
    .fill_src1       (fill_src1),
    .fill_src2       (fill_src2),
    .fill_mem        (fill_mem),
    .fill_state      (fill_state),
    .fill_exc        (fill_exc),
    .rsp_valid       (rsp_valid),
    .rsp_hit         (rsp_hit),
    .rsp_state       (rsp_state),
    .rsp_exc         (rsp_exc)
);

// File: tb/test_tpc_cache.sv
// Bench for tpc_cache with the default widths (8-bit opcode, 2-bit states,
// 14-bit key). Index = key[6:0] ^ key[13:7]. Keys A=0x0000, B=0x0081 and
// C=0x3FFF all fold to index 0; D=0x0005 folds to 5; E=0x0106 folds to 4.
module test_tpc_cache;

    localparam int CLK_PERIOD = 10;

    localparam logic [13:0] KA = 14'h0000;
    localparam logic [13:0] KB = 14'h0081;
    localparam logic [13:0] KC = 14'h3FFF;
    localparam logic [13:0] KD = 14'h0005;
    localparam logic [13:0] KE = 14'h0106;

    typedef struct packed {
        logic        lk;
        logic        fill;
        logic        flush;
        logic [13:0] lk_key;
        logic [13:0] fl_key;
        logic [1:0]  fl_st;
        logic        fl_exc;
        logic        e_hit;
        logic [1:0]  e_st;
        logic        e_exc;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, KA, KA, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0}, // R5 empty after reset
        '{1'b0, 1'b1, 1'b0, KA, KA, 2'd2, 1'b1, 1'b0, 2'd0, 1'b0}, // fill A
        '{1'b1, 1'b0, 1'b0, KA, KA, 2'd0, 1'b0, 1'b1, 2'd2, 1'b1}, // R4 hit A
        '{1'b1, 1'b0, 1'b0, KB, KA, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0}, // R3 B collides, misses
        '{1'b0, 1'b1, 1'b0, KA, KB, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0}, // fill B at index 0
        '{1'b1, 1'b0, 1'b0, KA, KA, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0}, // R6 R2 A replaced
        '{1'b1, 1'b0, 1'b0, KB, KA, 2'd0, 1'b0, 1'b1, 2'd1, 1'b0}, // R4 hit B
        '{1'b0, 1'b1, 1'b0, KA, KD, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0}, // fill D
        '{1'b1, 1'b0, 1'b0, KD, KA, 2'd0, 1'b0, 1'b1, 2'd3, 1'b0}, // R2 D own index
        '{1'b1, 1'b1, 1'b0, KC, KC, 2'd3, 1'b1, 1'b0, 2'd0, 1'b0}, // R9 lookup before fill
        '{1'b1, 1'b0, 1'b0, KC, KA, 2'd0, 1'b0, 1'b1, 2'd3, 1'b1}, // R4 hit C
        '{1'b0, 1'b1, 1'b1, KA, KD, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0}, // R8 flush plus fill
        '{1'b1, 1'b0, 1'b0, KD, KA, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0}, // R8 fill dropped
        '{1'b1, 1'b0, 1'b0, KC, KA, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0}, // R7 C flushed
        '{1'b0, 1'b1, 1'b0, KA, KD, 2'd2, 1'b1, 1'b0, 2'd0, 1'b0}, // refill D
        '{1'b1, 1'b0, 1'b0, KD, KA, 2'd0, 1'b0, 1'b1, 2'd2, 1'b1}, // R4 hit D
        '{1'b1, 1'b0, 1'b1, KD, KA, 2'd0, 1'b0, 1'b1, 2'd2, 1'b1}, // R9 lookup before flush
        '{1'b1, 1'b0, 1'b0, KD, KA, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0}  // R7 miss after flush
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       handler_addr_wr = 1'b0;
    logic       lk_valid = 1'b0;
    logic [13:0] lk_k = '0;
    logic       fill_valid = 1'b0;
    logic [13:0] fl_k = '0;
    logic [1:0] fill_state = '0;
    logic       fill_exc = 1'b0;
    logic       rsp_valid, rsp_hit, rsp_exc;
    logic [1:0] rsp_state;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tpc_cache i_tpc_cache (
        .clk             (clk),
        .rst_n           (rst_n),
        .handler_addr_wr (handler_addr_wr),
        .lk_valid        (lk_valid),
        .lk_opcode       (lk_k[13:6]),
        .lk_src1         (lk_k[5:4]),
        .lk_src2         (lk_k[3:2]),
        .lk_mem          (lk_k[1:0]),
        .fill_valid      (fill_valid),
        .fill_opcode     (fl_k[13:6]),
        .fill_src1       (fl_k[5:4]),
        .fill_src2       (fl_k[3:2]),
        .fill_mem        (fl_k[1:0]),
        .fill_state      (fill_state),
        .fill_exc        (fill_exc),
        .rsp_valid       (rsp_valid),
        .rsp_hit         (rsp_hit),
        .rsp_state       (rsp_state),
        .rsp_exc         (rsp_exc)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Check the response: hit flag and data, or quiet when idle.
    task automatic chk_rsp(input string req, input bit was_lk, input bit e_hit,
                           input int e_st, input bit e_exc);
        chk({req, " valid"}, rsp_valid, was_lk);
        chk({req, " hit"}, rsp_hit, was_lk && e_hit);
        if (was_lk) begin
            chk({req, " state"}, rsp_state, e_st);
            chk({req, " exc"}, rsp_exc, e_exc);
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 1'b0;
        fill_valid = 1'b0;
        handler_addr_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset valid", rsp_valid, 0);
        chk("R10 reset hit", rsp_hit, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: one active cycle, then check during an idle cycle.
        for (int i = 0; i < NVEC; i++) begin
            lk_valid = VECS[i].lk;
            lk_k = VECS[i].lk_key;
            fill_valid = VECS[i].fill;
            fl_k = VECS[i].fl_key;
            fill_state = VECS[i].fl_st;
            fill_exc = VECS[i].fl_exc;
            handler_addr_wr = VECS[i].flush;
            @(negedge clk);
            idle_inputs();
            // R1 response timing, R11 when the vector had no lookup
            chk_rsp($sformatf("R1 R11 vec%0d", i), VECS[i].lk, VECS[i].e_hit,
                    VECS[i].e_st, VECS[i].e_exc);
            @(negedge clk);
        end

        // R1: back-to-back lookups, each answered in its own next cycle.
        fill_valid = 1'b1; fl_k = KE; fill_state = 2'd1; fill_exc = 1'b1;
        @(negedge clk);
        fill_valid = 1'b1; fl_k = KD; fill_state = 2'd3; fill_exc = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
        lk_valid = 1'b1; lk_k = KD;
        @(negedge clk);
        chk_rsp("R1 b2b first", 1'b1, 1'b1, 3, 1'b1);
        lk_k = KE;
        @(negedge clk);
        chk_rsp("R1 b2b second", 1'b1, 1'b1, 1, 1'b1);
        lk_k = KA;
        @(negedge clk);
        lk_valid = 1'b0;
        chk_rsp("R5 b2b miss", 1'b1, 1'b0, 0, 1'b0);
        @(negedge clk);
        chk_rsp("R11 after b2b", 1'b0, 1'b0, 0, 1'b0);

        // R10: reset in mid-run invalidates the entries that were filled.
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 mid reset valid", rsp_valid, 0);
        rst_n = 1'b1;
        lk_valid = 1'b1; lk_k = KD;
        @(negedge clk);
        lk_valid = 1'b0;
        chk_rsp("R10 miss after reset", 1'b1, 1'b0, 0, 1'b0);
        @(negedge clk);

        finish_run();
    end

endmodule